// File: doc/BRIEF.md
# Multi-Mode Accumulator Operand Sequencer

This block is the control and datapath slice of a small accumulator machine. It runs a program held in an external word memory. Each instruction is fetched in two steps: the program counter is copied into the memory address register, and then the addressed word is captured as the current instruction. The word is split into an opcode, a mode digit and a signed address field. The block then forms the operand by the chosen mode: direct, immediate, indirect, PC-relative or indexed through an X register. A register-to-register move is also available. It runs only the extra memory cycles that mode needs, and changes the accumulator A, the X register, memory or the program counter.

The memory port has a combinational read: `mem_rdata` shows the word at `mem_addr` in the same cycle. Writes take place at the clock edge while `mem_we` is high. Raising `start` for one cycle while the block is idle or halted clears PC, A, X and the output register, and execution begins at address 0. The block keeps running until a halt instruction sets `done`, or an undefined encoding sets `error`.

Top module: `opseq_top`

## Requirements
- R1: A synchronous active-high reset leaves pc, acc, xreg, out_val, busy, done, error and mem_we all at 0.
- R2: The instruction word is {opcode[15:12], mode[11:9], field[8:0]}, and the field is read as a 9-bit two's complement value. Every instruction begins with two fetch cycles. In the second of them mem_addr equals pc. One cycle after `start` is sampled, busy is 1 and pc is 0.
- R3: MOV (opcode 10) uses register codes 0 = A and 1 = X. It copies the register coded in field[7:4] into the register coded in field[3:0] and advances pc in that same cycle, so the whole instruction takes 3 cycles.
- R4: Immediate mode (mode 1) loads or combines the sign-extended field into A or X with no memory access. This happens in cycle 3, and pc advances in cycle 4.
- R5: Relative mode (mode 3) uses the effective address pc + field, reduced modulo the memory size, so a negative result wraps to the top of memory. The data step is in cycle 4 and pc advances in cycle 5.
- R6: Indirect mode (mode 2) reads the word at the field address as a signed pointer, reduced modulo the memory size, and then reads the operand there. The data step is in cycle 5 and pc advances in cycle 6. Direct mode (mode 0) uses the field as the address and takes 5 cycles.
- R7: Indexed mode (mode 4) uses the address field + X. DECX (8) decrements X in 4 cycles. BRPX (9) branches to its effective address while X is non-negative, so a countdown loop ends when X steps from 0 to -1.
- R8: ADD (3) and SUB (4) wrap in 16-bit two's complement: 32767 + 1 gives -32768.
- R9: HLT (0) sets done and clears busy in cycle 3, with pc unchanged. done, pc and all registers then hold until the next start.
- R10: The following encodings set error, clear busy and keep pc in cycle 3: an undefined opcode (12..15), a mode above 4 on a memory or branch opcode, immediate mode on STA or a branch, and a MOV whose register code is above 1 or whose field bit 8 is set.
- R11: STA (2) writes A to memory at the effective address in one single-cycle write. OUT (5) copies A to out_val.
- R12: A summing loop over 20 table entries gives the true sum in out_val. This holds for the loop written with an indirect pointer and for the loop written with the X index.
- R13: The other opcodes are LDA (1), LDX (7), BRP (6, which branches while A is non-negative) and BR (11, which always branches). A branch takes 4 cycles, or 5 in indirect mode. A branch that is not taken advances pc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution at address 0 when idle or halted |
| mem_addr | output | 7 | Memory address (the address register) |
| mem_rdata | input | 16 | Word at mem_addr, combinational |
| mem_wdata | output | 16 | Write data (A) |
| mem_we | output | 1 | Write enable, taken at the clock edge |
| pc | output | 7 | Program counter |
| acc | output | 16 | Accumulator A |
| xreg | output | 16 | Index register X |
| out_val | output | 16 | Output register written by OUT |
| busy | output | 1 | Executing a program |
| done | output | 1 | Halted by HLT |
| error | output | 1 | Halted on an undefined encoding |

## Verification
The first program walks through every addressing mode once. It uses a negative immediate, moves in both directions between A and X, a negative relative offset that wraps below address 0, an index with a non-zero X, an indirect pointer, an overflowing add, and one branch taken and one not taken. These show whether each mode picks the right address and spends the right number of cycles. Two summing loops over a table that holds negative entries separate a pointer that is advanced in memory from an index that counts down. The 0 to -1 exit shows whether the X test is signed. Short programs that end on each class of undefined encoding separate an error halt from a normal halt.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

    localparam int DATA_W   = 16;
    localparam int OP_W     = 4;
    localparam int MODE_W   = 3;
    localparam int FIELD_W  = DATA_W - OP_W - MODE_W;
    localparam int RSEL_W   = 4;

    localparam logic [OP_W-1:0] OP_HLT  = 4'd0;
    localparam logic [OP_W-1:0] OP_LDA  = 4'd1;
    localparam logic [OP_W-1:0] OP_STA  = 4'd2;
    localparam logic [OP_W-1:0] OP_ADD  = 4'd3;
    localparam logic [OP_W-1:0] OP_SUB  = 4'd4;
    localparam logic [OP_W-1:0] OP_OUT  = 4'd5;
    localparam logic [OP_W-1:0] OP_BRP  = 4'd6;
    localparam logic [OP_W-1:0] OP_LDX  = 4'd7;
    localparam logic [OP_W-1:0] OP_DECX = 4'd8;
    localparam logic [OP_W-1:0] OP_BRPX = 4'd9;
    localparam logic [OP_W-1:0] OP_MOV  = 4'd10;
    localparam logic [OP_W-1:0] OP_BR   = 4'd11;

    localparam logic [MODE_W-1:0] MD_DIR = 3'd0;
    localparam logic [MODE_W-1:0] MD_IMM = 3'd1;
    localparam logic [MODE_W-1:0] MD_IND = 3'd2;
    localparam logic [MODE_W-1:0] MD_REL = 3'd3;
    localparam logic [MODE_W-1:0] MD_IDX = 3'd4;

    typedef struct packed {
        logic [OP_W-1:0]    op;
        logic [MODE_W-1:0]  mode;
        logic [FIELD_W-1:0] field;
    } instr_t;

    typedef enum logic [2:0] {
        CL_HALT, CL_BAD, CL_MOV, CL_REG, CL_MEM, CL_JMP
    } iclass_e;

    typedef struct packed {
        iclass_e cls;
        logic    imm;
        logic    ind;
        logic    to_x;
        logic    store;
    } dec_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_IRLD, ST_EXEC, ST_PTR, ST_OPER, ST_PCINC, ST_HALT
    } state_e;

    function automatic int wrap_addr(input int v, input int n);
        int r;
        r = v % n;
        if (r < 0) r = r + n;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] sext_field(input logic [FIELD_W-1:0] f);
        return {{(DATA_W-FIELD_W){f[FIELD_W-1]}}, f};
    endfunction

endpackage

// File: rtl/opseq_decode.sv
module opseq_decode
    import opseq_pkg::*;
(
    input  instr_t ir,
    output dec_t   dec
);
    logic mode_ok;
    logic reg_ok;

    always_comb begin
        mode_ok   = (ir.mode <= MD_IDX);
        reg_ok    = (ir.field[FIELD_W-1] == 1'b0)
                 && (ir.field[2*RSEL_W-1:RSEL_W] <= RSEL_W'(1))
                 && (ir.field[RSEL_W-1:0] <= RSEL_W'(1));
        dec.cls   = CL_BAD;
        dec.imm   = (ir.mode == MD_IMM);
        dec.ind   = (ir.mode == MD_IND);
        dec.to_x  = (ir.op == OP_LDX);
        dec.store = (ir.op == OP_STA);
        case (ir.op)
            OP_HLT:                         dec.cls = CL_HALT;
            OP_LDA, OP_ADD, OP_SUB, OP_LDX: if (mode_ok) dec.cls = CL_MEM;
            OP_STA:                         if (mode_ok && ir.mode != MD_IMM) dec.cls = CL_MEM;
            OP_BRP, OP_BRPX, OP_BR:         if (mode_ok && ir.mode != MD_IMM) dec.cls = CL_JMP;
            OP_OUT, OP_DECX:                dec.cls = CL_REG;
            OP_MOV:                         if (reg_ok) dec.cls = CL_MOV;
            default:                        dec.cls = CL_BAD;
        endcase
    end
endmodule

// File: rtl/opseq_agen.sv
module opseq_agen
    import opseq_pkg::*;
#(
    parameter int MEM_WORDS = 100,
    parameter int ADDR_W    = $clog2(MEM_WORDS)
) (
    input  logic [MODE_W-1:0]  mode,
    input  logic [FIELD_W-1:0] field,
    input  logic [ADDR_W-1:0]  pc,
    input  logic [DATA_W-1:0]  xval,
    output logic [ADDR_W-1:0]  ea
);
    int base;
    int offs;

    always_comb begin
        offs = int'($signed(sext_field(field)));
        case (mode)
            MD_REL:  base = int'(pc);
            MD_IDX:  base = int'($signed(xval));
            default: base = 0;
        endcase
        ea = ADDR_W'(wrap_addr(base + offs, MEM_WORDS));
    end
endmodule

// File: rtl/opseq_alu.sv
module opseq_alu
    import opseq_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result
);
    always_comb begin
        case (op)
            OP_ADD:  result = a + operand;
            OP_SUB:  result = a - operand;
            OP_LDA,
            OP_LDX:  result = operand;
            default: result = a;
        endcase
    end
endmodule

// File: rtl/opseq_top.sv
module opseq_top
    import opseq_pkg::*;
#(
    parameter int MEM_WORDS = 100,
    parameter int ADDR_W    = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] xreg,
    output logic [DATA_W-1:0] out_val,
    output logic              busy,
    output logic              done,
    output logic              error
);
    state_e            state_q;
    instr_t            ir_q;
    logic [ADDR_W-1:0] pc_q, mar_q;
    logic [DATA_W-1:0] acc_q, x_q, out_q;
    logic              done_q, err_q;

    dec_t              dec;
    logic [ADDR_W-1:0] ea, ptr_addr, pc_inc;
    logic [DATA_W-1:0] operand, alu_res, mov_src;
    logic              jmp_take;

    opseq_decode u_dec (.ir(ir_q), .dec(dec));

    opseq_agen #(.MEM_WORDS(MEM_WORDS), .ADDR_W(ADDR_W)) u_agen (
        .mode(ir_q.mode), .field(ir_q.field), .pc(pc_q), .xval(x_q), .ea(ea)
    );

    assign operand = (state_q == ST_EXEC) ? sext_field(ir_q.field) : mem_rdata;

    opseq_alu u_alu (.op(ir_q.op), .a(acc_q), .operand(operand), .result(alu_res));

    assign pc_inc   = (pc_q == ADDR_W'(MEM_WORDS-1)) ? '0 : pc_q + 1'b1;
    assign ptr_addr = ADDR_W'(wrap_addr(int'($signed(mem_rdata)), MEM_WORDS));
    assign mov_src  = ir_q.field[RSEL_W] ? x_q : acc_q;

    always_comb begin
        case (ir_q.op)
            OP_BRP:  jmp_take = ~acc_q[DATA_W-1];
            OP_BRPX: jmp_take = ~x_q[DATA_W-1];
            default: jmp_take = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ir_q    <= '0;
            pc_q    <= '0;
            mar_q   <= '0;
            acc_q   <= '0;
            x_q     <= '0;
            out_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE, ST_HALT: begin
                    if (start) begin
                        pc_q    <= '0;
                        acc_q   <= '0;
                        x_q     <= '0;
                        out_q   <= '0;
                        done_q  <= 1'b0;
                        err_q   <= 1'b0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    mar_q   <= pc_q;
                    state_q <= ST_IRLD;
                end
                ST_IRLD: begin
                    ir_q    <= instr_t'(mem_rdata);
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    case (dec.cls)
                        CL_HALT: begin
                            done_q  <= 1'b1;
                            state_q <= ST_HALT;
                        end
                        CL_MOV: begin
                            if (ir_q.field[0]) x_q <= mov_src;
                            else               acc_q <= mov_src;
                            pc_q    <= pc_inc;
                            state_q <= ST_FETCH;
                        end
                        CL_REG: begin
                            if (ir_q.op == OP_OUT) out_q <= acc_q;
                            else                   x_q   <= x_q - 1'b1;
                            state_q <= ST_PCINC;
                        end
                        CL_MEM, CL_JMP: begin
                            if (dec.imm) begin
                                if (dec.to_x) x_q   <= alu_res;
                                else          acc_q <= alu_res;
                                state_q <= ST_PCINC;
                            end else begin
                                mar_q   <= ea;
                                state_q <= dec.ind ? ST_PTR : ST_OPER;
                            end
                        end
                        default: begin
                            err_q   <= 1'b1;
                            state_q <= ST_HALT;
                        end
                    endcase
                end
                ST_PTR: begin
                    mar_q   <= ptr_addr;
                    state_q <= ST_OPER;
                end
                ST_OPER: begin
                    if (dec.cls == CL_JMP) begin
                        pc_q    <= jmp_take ? mar_q : pc_inc;
                        state_q <= ST_FETCH;
                    end else begin
                        if (!dec.store) begin
                            if (dec.to_x) x_q   <= alu_res;
                            else          acc_q <= alu_res;
                        end
                        state_q <= ST_PCINC;
                    end
                end
                ST_PCINC: begin
                    pc_q    <= pc_inc;
                    state_q <= ST_FETCH;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = acc_q;
    assign mem_we    = (state_q == ST_OPER) && dec.store && (dec.cls == CL_MEM);
    assign pc        = pc_q;
    assign acc       = acc_q;
    assign xreg      = x_q;
    assign out_val   = out_q;
    assign busy      = (state_q != ST_IDLE) && (state_q != ST_HALT);
    assign done      = done_q;
    assign error     = err_q;

endmodule

// File: rtl/opseq_chk.sv
module opseq_chk #(
    parameter int MEM_WORDS = 100,
    parameter int ADDR_W    = $clog2(MEM_WORDS)
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              mem_we,
    input logic [ADDR_W-1:0] pc,
    input logic              busy,
    input logic              done,
    input logic              error
);
    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(pc)));

    // R10
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        error |-> !busy);

    // R9
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    // R11
    we_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R11
    we_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R2
    pc_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(pc) < MEM_WORDS);
endmodule

bind opseq_top opseq_chk #(.MEM_WORDS(MEM_WORDS), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .start(start), .mem_we(mem_we), .pc(pc),
    .busy(busy), .done(done), .error(error)
);

// File: tb/opseq_top_tb.sv
module opseq_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 100;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [6:0]  mem_addr;
    logic [15:0] mem_rdata, mem_wdata, acc, xreg, out_val;
    logic        mem_we, busy, done, error;
    logic [6:0]  pc;

    logic [15:0] dmem [0:N-1];
    logic [15:0] rmem [0:N-1];

    int total = 0;
    int bad = 0;

    logic [6:0]  e_pc;
    logic [15:0] e_a, e_x, e_out;
    logic        e_busy, e_done, e_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = dmem[mem_addr];
    always @(posedge clk) if (mem_we) dmem[mem_addr] <= mem_wdata;

    opseq_top dut_i (
        .clk(clk), .rst(rst), .start(start), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .pc(pc), .acc(acc), .xreg(xreg), .out_val(out_val),
        .busy(busy), .done(done), .error(error)
    );

    function automatic logic [15:0] ins(input int op, input int md, input int f);
        return 16'(((op & 15) << 12) | ((md & 7) << 9) | (f & 511));
    endfunction

    function automatic int wrapm(input int v);
        return ((v % N) + N) % N;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmp_all(input string tag);
        chk({tag, " pc"}, 32'(pc), 32'(e_pc));
        chk({tag, " acc"}, 32'(acc), 32'(e_a));
        chk({tag, " xreg"}, 32'(xreg), 32'(e_x));
        chk({tag, " out_val"}, 32'(out_val), 32'(e_out));
        chk({tag, " busy"}, 32'(busy), 32'(e_busy));
        chk({tag, " done"}, 32'(done), 32'(e_done));
        chk({tag, " error"}, 32'(error), 32'(e_err));
    endtask

    task automatic clear_mem();
        for (int i = 0; i < N; i++) begin
            dmem[i] = '0;
            rmem[i] = '0;
        end
    endtask

    task automatic put(input int a, input logic [15:0] w);
        dmem[a] = w;
        rmem[a] = w;
    endtask

    // Behavioural reference: one instruction at a time, with its own cycle schedule.
    task automatic run_prog();
        int guard;
        bit halted;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        e_pc = '0; e_a = '0; e_x = '0; e_out = '0;
        e_busy = 1'b1; e_done = 1'b0; e_err = 1'b0;
        cmp_all("R2 start");
        halted = 0;
        guard = 0;
        while (!halted && guard < 4000) begin
            logic [15:0] w, opv, n_a, n_x, n_out;
            logic [6:0]  n_pc;
            int op, md, fld, ea, len, kd;
            bit illegal, isbr, wr, stop;
            string tag;
            guard++;
            w = rmem[e_pc];
            op = int'(w[15:12]);
            md = int'(w[11:9]);
            fld = int'($signed(w[8:0]));
            n_a = e_a; n_x = e_x; n_out = e_out;
            n_pc = 7'(wrapm(int'(e_pc) + 1));
            illegal = 0; wr = 0; stop = 0; ea = 0; opv = '0;
            len = 3; kd = 3;
            isbr = (op == 6 || op == 9 || op == 11);
            case (md)
                1: tag = "R4 imm";
                2: tag = "R6 ind";
                3: tag = "R5 rel";
                4: tag = "R7 idx";
                default: tag = "R6 dir";
            endcase
            if (op == 0) begin
                stop = 1; tag = "R9 halt";
            end else if (op == 1 || op == 2 || op == 3 || op == 4 || op == 7 || isbr) begin
                if (md > 4 || (md == 1 && (op == 2 || isbr))) illegal = 1;
                else begin
                    if (md == 1) begin
                        opv = 16'(fld); len = 4; kd = 3;
                    end else begin
                        case (md)
                            0: ea = wrapm(fld);
                            2: ea = wrapm(int'($signed(rmem[wrapm(fld)])));
                            3: ea = wrapm(int'(e_pc) + fld);
                            default: ea = wrapm(fld + int'($signed(e_x)));
                        endcase
                        len = (md == 2) ? 6 : 5;
                        kd = len - 1;
                        opv = rmem[ea];
                    end
                    case (op)
                        1: n_a = opv;
                        2: wr = 1;
                        3: n_a = e_a + opv;
                        4: n_a = e_a - opv;
                        7: n_x = opv;
                        default: begin
                            len = len - 1;
                            tag = "R13 branch";
                            if (op == 11 || (op == 6 && !e_a[15]) || (op == 9 && !e_x[15])) n_pc = 7'(ea);
                            if (op == 9) tag = "R7 brpx";
                        end
                    endcase
                end
            end else if (op == 5 || op == 8) begin
                len = 4; kd = 3;
                if (op == 5) begin n_out = e_a; tag = "R11 out"; end
                else begin n_x = e_x - 16'd1; tag = "R7 decx"; end
            end else if (op == 10) begin
                tag = "R3 mov";
                if (w[8] || w[7:4] > 4'd1 || w[3:0] > 4'd1) illegal = 1;
                else if (w[0]) n_x = w[4] ? e_x : e_a;
                else n_a = w[4] ? e_x : e_a;
            end else illegal = 1;
            if (illegal) tag = "R10 illegal";
            if (illegal || stop) n_pc = e_pc;
            for (int c = 1; c <= len; c++) begin
                @(negedge clk);
                if (c == 1) chk("R2 fetch address", 32'(mem_addr), 32'(e_pc));
                if (c == kd && !illegal && !stop) begin
                    e_a = n_a; e_x = n_x; e_out = n_out;
                    if (wr) rmem[ea] = e_a;
                end
                if (c == len) begin
                    e_pc = n_pc;
                    if (illegal) begin e_err = 1'b1; e_busy = 1'b0; halted = 1; end
                    if (stop) begin e_done = 1'b1; e_busy = 1'b0; halted = 1; end
                end
                cmp_all(tag);
            end
        end
        for (int i = 0; i < N; i++) chk("R11 memory image", 32'(dmem[i]), 32'(rmem[i]));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int sum;
        clear_mem();
        repeat (3) @(posedge clk);
        @(negedge clk);
        e_pc = '0; e_a = '0; e_x = '0; e_out = '0;
        e_busy = 0; e_done = 0; e_err = 0;
        cmp_all("R1 reset");
        chk("R1 reset mem_we", 32'(mem_we), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // Mode walk-through
        put(0,  ins(1, 1, -5));
        put(1,  ins(10, 0, 16'h001));
        put(2,  ins(1, 1, 7));
        put(3,  ins(10, 0, 16'h010));
        put(4,  ins(2, 3, 46));
        put(5,  ins(1, 3, -10));
        put(6,  ins(3, 0, 50));
        put(7,  ins(7, 1, 3));
        put(8,  ins(3, 4, 90));
        put(9,  ins(4, 2, 96));
        put(10, ins(5, 0, 0));
        put(11, ins(1, 0, 94));
        put(12, ins(3, 1, 1));
        put(13, ins(2, 0, 51));
        put(14, ins(8, 0, 0));
        put(15, ins(9, 0, 17));
        put(16, ins(0, 0, 0));
        put(17, ins(6, 0, 16));
        put(18, ins(0, 0, 0));
        put(93, 16'd10);
        put(94, 16'd32767);
        put(95, 16'd1234);
        put(96, 16'd97);
        put(97, 16'd39);
        run_prog();
        chk("R5 relative store at 50", 32'(dmem[50]), 32'(16'hFFFB));
        chk("R8 wrapped sum stored", 32'(dmem[51]), 32'(16'h8000));
        chk("R11 out_val", 32'(out_val), 32'd1200);
        chk("R9 done", 32'(done), 32'd1);
        repeat (4) @(negedge clk);
        chk("R9 held pc", 32'(pc), 32'd18);
        chk("R9 held done", 32'(done), 32'd1);
        chk("R9 held busy", 32'(busy), 32'd0);

        // Indirect summing loop
        clear_mem();
        sum = 0;
        for (int i = 0; i < 20; i++) begin
            put(60 + i, 16'(i * 37 - 200));
            sum += i * 37 - 200;
        end
        put(0,  ins(1, 0, 90));
        put(1,  ins(2, 0, 97));
        put(2,  ins(1, 1, 0));
        put(3,  ins(2, 0, 99));
        put(4,  ins(1, 1, 19));
        put(5,  ins(2, 0, 98));
        put(6,  ins(1, 0, 99));
        put(7,  ins(3, 2, 97));
        put(8,  ins(2, 0, 99));
        put(9,  ins(1, 0, 97));
        put(10, ins(3, 1, 1));
        put(11, ins(2, 0, 97));
        put(12, ins(1, 0, 98));
        put(13, ins(4, 1, 1));
        put(14, ins(2, 0, 98));
        put(15, ins(6, 0, 6));
        put(16, ins(1, 0, 99));
        put(17, ins(5, 0, 0));
        put(18, ins(0, 0, 0));
        put(90, 16'd60);
        run_prog();
        chk("R12 indirect loop sum", 32'(out_val), 32'(16'(sum)));

        // Indexed summing loop
        put(0, ins(1, 1, 0));
        put(1, ins(7, 1, 19));
        put(2, ins(3, 4, 60));
        put(3, ins(8, 0, 0));
        put(4, ins(9, 0, 2));
        put(5, ins(5, 0, 0));
        put(6, ins(0, 0, 0));
        run_prog();
        chk("R12 indexed loop sum", 32'(out_val), 32'(16'(sum)));
        chk("R7 X after exit", 32'(xreg), 32'(16'hFFFF));

        // Undefined encodings
        clear_mem();
        put(0, ins(1, 1, 1));
        put(1, ins(13, 0, 0));
        run_prog();
        chk("R10 bad opcode error", 32'(error), 32'd1);
        chk("R10 bad opcode pc", 32'(pc), 32'd1);
        put(1, ins(1, 6, 0));
        run_prog();
        chk("R10 bad mode error", 32'(error), 32'd1);
        put(1, ins(2, 1, 5));
        run_prog();
        chk("R10 immediate store error", 32'(error), 32'd1);
        chk("R10 immediate store no write", 32'(dmem[5]), 32'd0);
        put(1, ins(10, 0, 16'h021));
        run_prog();
        chk("R10 bad register error", 32'(error), 32'd1);
        chk("R10 bad register acc kept", 32'(acc), 32'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule